// File: doc/BRIEF.md
# Dynamic Home Tile Candidate Generator

In a 16-tile mesh with one cache bank per tile, each core can spread its blocks over a cluster of 1, 2, 4, 8 or 16 banks. The block's home-select address field picks the bank. This generator takes that field, the requesting core's tile number and the core's current cluster size. It returns the tile that currently homes the block under that size.

A core may resize its cluster between accesses, so an older copy of the block can sit in a tile chosen under a different size. To cover this, the block also returns a 16-bit set of every tile that could home the block under any of the five sizes. A lookup can be multicast to that whole set. The block also reports how many tiles the set holds and the static home tile, which is the address field used unchanged.

Each request is taken on a valid strobe. All results appear together in registers one clock later and hold until the next request.

Top module: `dht_candidate_gen`

## Requirements
- R1: While reset is asserted and after its release, before any request, `res_valid`, `cur_tile`, `static_tile`, `cand_set`, `cand_num` and `size_err` are all zero.
- R2: `res_valid` is high in exactly the cycles that follow a cycle with `req_valid` high.
- R3: `cur_tile` equals `(home_sel AND m) OR (core_id AND NOT m)`. The mask m is 0000, 0001, 0101, 0111 or 1111 for `size_code` 0, 1, 2, 3 or 4, which select clusters of 1, 2, 4, 8 or 16 banks.
- R4: `static_tile` equals the requested `home_sel`. With `size_code` 4 it also equals `cur_tile`.
- R5: Bit t of `cand_set` is set exactly when tile t is the R3 result for at least one of the five size codes 0 to 4.
- R6: `cand_num` equals the number of set bits in `cand_set` and lies between 1 and 5. It is 5 for home_sel 1111 with core 0000, and 1 for home_sel 0000 with core 0000.
- R7: A `size_code` of 5, 6 or 7 sets `size_err`, and the request is handled as a 16-bank cluster. A legal code clears `size_err`.
- R8: A cycle with `req_valid` low leaves `cur_tile`, `static_tile`, `cand_set`, `cand_num` and `size_err` unchanged.
- R9: Whenever `res_valid` is high, the bits of `cand_set` at `static_tile` and at `cur_tile` are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| home_sel | input | 4 | Home-select address field of the block |
| core_id | input | 4 | Tile number of the requesting core |
| size_code | input | 3 | Cluster size code, 0..4 for 1..16 banks |
| res_valid | output | 1 | Results belong to the previous cycle's request |
| cur_tile | output | 4 | Home tile under the current cluster size |
| static_tile | output | 4 | Home tile for the full 16-bank cluster |
| cand_set | output | 16 | Set of all possible home tiles |
| cand_num | output | 3 | Number of tiles in `cand_set` |
| size_err | output | 1 | Request carried an illegal size code |

## Verification
A wrong mask entry for a single cluster size shows up in two ways. It misplaces `cur_tile` only for requests that use that code, and it corrupts `cand_set` and `cand_num` for every request whose address and core bits differ under the bad mask. Every result is registered, so any such fault appears at the ports in the cycle right after the strobe. A fault in the hold path shows up one cycle after the first idle cycle. The bench compares every output on every clock against a behavioural model. It includes both extreme address and core pairs, every illegal code, and idle gaps between requests.

// File: rtl/dht_pkg.sv
package dht_pkg;
   // Mask layout choices for the per-size bank masks
   localparam int unsigned MASK_SPREAD = 0;  // 0000/0001/0101/0111/1111 layout
   localparam int unsigned MASK_LOWBIT = 1;  // contiguous low-order bits

   // Count of legal cluster sizes for a given tile index width
   function automatic int unsigned num_sizes(input int unsigned tile_bits);
      return tile_bits + 1;
   endfunction
endpackage

// File: rtl/dht_mask_rom.sv
// Bank mask for one cluster size index (0 = single bank ... TILE_BITS = all banks)
module dht_mask_rom #(
   parameter int unsigned TILE_BITS  = 4,
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned MASK_STYLE = dht_pkg::MASK_SPREAD
) (
   input  logic [IDX_W-1:0]     size_idx,
   output logic [TILE_BITS-1:0] mask
);
   generate
      if (MASK_STYLE == dht_pkg::MASK_SPREAD) begin : g_spread
         if (TILE_BITS != 4) begin : g_bad_width
            $error("spread mask layout is defined for 4 tile bits only");
         end
         logic [3:0] tbl;
         always_comb begin
            case (size_idx)
               IDX_W'(0): tbl = 4'b0000;
               IDX_W'(1): tbl = 4'b0001;
               IDX_W'(2): tbl = 4'b0101;
               IDX_W'(3): tbl = 4'b0111;
               default:   tbl = 4'b1111;
            endcase
         end
         assign mask = TILE_BITS'(tbl);
      end else begin : g_lowbit
         always_comb begin
            for (int i = 0; i < int'(TILE_BITS); i++) begin
               mask[i] = (i < int'(size_idx));
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dht_tile_select.sv
// Picks address bits where the mask is set and core bits elsewhere
module dht_tile_select #(
   parameter int unsigned TILE_BITS = 4
) (
   input  logic [TILE_BITS-1:0] home_bits,
   input  logic [TILE_BITS-1:0] core_bits,
   input  logic [TILE_BITS-1:0] mask,
   output logic [TILE_BITS-1:0] tile
);
   assign tile = (home_bits & mask) | (core_bits & ~mask);
endmodule

// File: rtl/dht_candidate_union.sv
// Union of home tiles over every legal cluster size, plus its population count
module dht_candidate_union #(
   parameter int unsigned TILE_BITS  = 4,
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned CNT_W      = 3,
   parameter int unsigned MASK_STYLE = dht_pkg::MASK_SPREAD
) (
   input  logic [TILE_BITS-1:0]        home_bits,
   input  logic [TILE_BITS-1:0]        core_bits,
   output logic [(1<<TILE_BITS)-1:0]   cand,
   output logic [CNT_W-1:0]            cand_cnt
);
   localparam int unsigned NUM_TILES = 1 << TILE_BITS;
   localparam int unsigned NUM_SIZES = dht_pkg::num_sizes(TILE_BITS);

   logic [TILE_BITS-1:0] size_mask [NUM_SIZES];
   logic [TILE_BITS-1:0] size_tile [NUM_SIZES];
   logic [NUM_TILES-1:0] size_hot  [NUM_SIZES];

   generate
      for (genvar k = 0; k < int'(NUM_SIZES); k++) begin : g_size
         dht_mask_rom #(
            .TILE_BITS (TILE_BITS),
            .IDX_W     (IDX_W),
            .MASK_STYLE(MASK_STYLE)
         ) u_rom (
            .size_idx(IDX_W'(k)),
            .mask    (size_mask[k])
         );
         dht_tile_select #(.TILE_BITS(TILE_BITS)) u_sel (
            .home_bits(home_bits),
            .core_bits(core_bits),
            .mask     (size_mask[k]),
            .tile     (size_tile[k])
         );
         assign size_hot[k] = NUM_TILES'(1) << size_tile[k];
      end
   endgenerate

   always_comb begin
      cand = '0;
      for (int k = 0; k < int'(NUM_SIZES); k++) begin
         cand = cand | size_hot[k];
      end
   end

   always_comb begin
      cand_cnt = '0;
      for (int t = 0; t < int'(NUM_TILES); t++) begin
         cand_cnt = cand_cnt + CNT_W'(cand[t]);
      end
   end
endmodule

// File: rtl/dht_candidate_gen.sv
module dht_candidate_gen #(
   parameter int unsigned TILE_BITS  = 4,
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned MASK_STYLE = dht_pkg::MASK_SPREAD
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [TILE_BITS-1:0]         home_sel,
   input  logic [TILE_BITS-1:0]         core_id,
   input  logic [CODE_W-1:0]            size_code,
   output logic                         res_valid,
   output logic [TILE_BITS-1:0]         cur_tile,
   output logic [TILE_BITS-1:0]         static_tile,
   output logic [(1<<TILE_BITS)-1:0]    cand_set,
   output logic [$clog2(TILE_BITS+2)-1:0] cand_num,
   output logic                         size_err
);
   localparam int unsigned NUM_TILES = 1 << TILE_BITS;
   localparam int unsigned NUM_SIZES = dht_pkg::num_sizes(TILE_BITS);
   localparam int unsigned CNT_W     = $clog2(NUM_SIZES + 1);
   localparam int unsigned TOP_IDX   = NUM_SIZES - 1;

   generate
      if (TILE_BITS < 1 || TILE_BITS > 8) begin : g_chk_tiles
         $error("TILE_BITS must lie in 1..8");
      end
      if (CODE_W < $clog2(NUM_SIZES)) begin : g_chk_code
         $error("CODE_W too narrow for all cluster sizes");
      end
   endgenerate

   // Illegal codes fall back to the full-width cluster
   logic              code_bad;
   logic [CODE_W-1:0] size_idx;
   assign code_bad = (size_code > CODE_W'(TOP_IDX));
   assign size_idx = code_bad ? CODE_W'(TOP_IDX) : size_code;

   logic [TILE_BITS-1:0] cur_mask;
   logic [TILE_BITS-1:0] cur_next;
   logic [NUM_TILES-1:0] cand_next;
   logic [CNT_W-1:0]     cnt_next;

   dht_mask_rom #(
      .TILE_BITS (TILE_BITS),
      .IDX_W     (CODE_W),
      .MASK_STYLE(MASK_STYLE)
   ) u_cur_rom (
      .size_idx(size_idx),
      .mask    (cur_mask)
   );

   dht_tile_select #(.TILE_BITS(TILE_BITS)) u_cur_sel (
      .home_bits(home_sel),
      .core_bits(core_id),
      .mask     (cur_mask),
      .tile     (cur_next)
   );

   dht_candidate_union #(
      .TILE_BITS (TILE_BITS),
      .IDX_W     (CODE_W),
      .CNT_W     (CNT_W),
      .MASK_STYLE(MASK_STYLE)
   ) u_union (
      .home_bits(home_sel),
      .core_bits(core_id),
      .cand     (cand_next),
      .cand_cnt (cnt_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         cur_tile    <= '0;
         static_tile <= '0;
         cand_set    <= '0;
         cand_num    <= '0;
         size_err    <= 1'b0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            cur_tile    <= cur_next;
            static_tile <= home_sel;
            cand_set    <= cand_next;
            cand_num    <= cnt_next;
            size_err    <= code_bad;
         end
      end
   end
endmodule

// File: rtl/dht_candidate_gen_chk.sv
module dht_candidate_gen_chk #(
   parameter int unsigned TILE_BITS = 4,
   parameter int unsigned CODE_W    = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           req_valid,
   input logic [TILE_BITS-1:0]           home_sel,
   input logic [CODE_W-1:0]              size_code,
   input logic                           res_valid,
   input logic [TILE_BITS-1:0]           cur_tile,
   input logic [TILE_BITS-1:0]           static_tile,
   input logic [(1<<TILE_BITS)-1:0]      cand_set,
   input logic [$clog2(TILE_BITS+2)-1:0] cand_num,
   input logic                           size_err
);
   localparam int unsigned TOP_IDX = TILE_BITS;

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);
   a_r4_static_is_field: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> static_tile == $past(home_sel));
   a_r6_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (32'(cand_num) == 32'($countones(cand_set))));
   a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (cand_num >= 1 && 32'(cand_num) <= TOP_IDX + 1));
   a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && size_code > CODE_W'(TOP_IDX)) |=>
         (size_err && cur_tile == $past(home_sel)));
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(cand_set) && $stable(cur_tile) && $stable(size_err)));
   a_r9_static_member: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> cand_set[static_tile]);
   a_r9_current_member: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> cand_set[cur_tile]);
endmodule

bind dht_candidate_gen dht_candidate_gen_chk #(
   .TILE_BITS(TILE_BITS),
   .CODE_W   (CODE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .home_sel   (home_sel),
   .size_code  (size_code),
   .res_valid  (res_valid),
   .cur_tile   (cur_tile),
   .static_tile(static_tile),
   .cand_set   (cand_set),
   .cand_num   (cand_num),
   .size_err   (size_err)
);

// File: tb/tb_dht_candidate_gen.sv
module tb_dht_candidate_gen;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  home_sel = '0;
   logic [3:0]  core_id = '0;
   logic [2:0]  size_code = '0;
   logic        res_valid;
   logic [3:0]  cur_tile;
   logic [3:0]  static_tile;
   logic [15:0] cand_set;
   logic [2:0]  cand_num;
   logic        size_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // Expected port values for the next comparison
   int e_valid = 0, e_cur = 0, e_stat = 0, e_set = 0, e_num = 0, e_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dht_candidate_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .home_sel(home_sel), .core_id(core_id), .size_code(size_code),
      .res_valid(res_valid), .cur_tile(cur_tile), .static_tile(static_tile),
      .cand_set(cand_set), .cand_num(cand_num), .size_err(size_err)
   );

   function automatic int mask_of(input int code);
      case (code)
         0: return 0;
         1: return 1;
         2: return 5;
         3: return 7;
         default: return 15;
      endcase
   endfunction

   function automatic int place(input int hs, input int id, input int code);
      int m = mask_of(code);
      return ((hs & m) | (id & ~m)) & 15;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R2", "res_valid", int'(res_valid), e_valid);
      check("R3", "cur_tile", int'(cur_tile), e_cur);
      check("R4", "static_tile", int'(static_tile), e_stat);
      check("R5", "cand_set", int'(cand_set), e_set);
      check("R6", "cand_num", int'(cand_num), e_num);
      check("R7", "size_err", int'(size_err), e_err);
      if (e_valid != 0) begin
         check("R9", "static bit in set", int'(cand_set[static_tile]), 1);
         check("R9", "current bit in set", int'(cand_set[cur_tile]), 1);
      end
   endtask

   // One cycle: compare outputs from the last request, then drive the next
   task automatic step(input bit v, input int hs, input int id, input int code);
      @(negedge clk);
      compare_all();
      req_valid = v;
      home_sel  = 4'(hs);
      core_id   = 4'(id);
      size_code = 3'(code);
      e_valid   = v;
      if (v) begin
         int set = 0;
         int num = 0;
         for (int c = 0; c < 5; c++) set |= (1 << place(hs, id, c));
         for (int t = 0; t < 16; t++) num += (set >> t) & 1;
         e_cur  = place(hs, id, (code > 4) ? 4 : code);
         e_stat = hs;
         e_set  = set;
         e_num  = num;
         e_err  = (code > 4);
      end
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "res_valid in reset", int'(res_valid), 0);
      check("R1", "cand_set in reset", int'(cand_set), 0);
      check("R1", "cand_num in reset", int'(cand_num), 0);
      rst_n = 1'b1;
      step(0, 0, 0, 0);   // R1: still zero after release

      // R3: HS 1111, core 0101 over all sizes -> 5,5,5,7,15
      for (int c = 0; c < 5; c++) step(1, 15, 5, c);
      step(0, 0, 0, 0);
      // R6: HS 1111, core 0000 -> five candidates 0,1,5,7,15
      step(1, 15, 0, 2);
      // R6: HS 0000, core 0000 -> single candidate
      step(1, 0, 0, 0);
      // R4: full cluster equals static tile
      step(1, 9, 3, 4);
      // R7: illegal codes, then legal code clears the flag
      for (int c = 5; c < 8; c++) step(1, 10, 6, c);
      step(1, 10, 6, 1);
      // R8: idle cycles with changing inputs must not alter outputs
      step(0, 3, 12, 7);
      step(0, 14, 1, 0);
      step(0, 5, 5, 3);
      // Mixed stream of requests and gaps
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 4) != 0, int'($urandom % 16), int'($urandom % 16),
              int'($urandom % 8));
      end
      step(0, 0, 0, 0);
      @(negedge clk);
      compare_all();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule